// File: doc/BRIEF.md
# Complex Reciprocal Prescale Table Lookup

This block turns a complex divisor into a short-precision prescale factor K close to 1/d. The divisor arrives as two two's-complement fractions, a real and an imaginary part, with the larger component magnitude in [1/2, 1). Multiplying both operands of a complex division by K makes the scaled divisor almost exactly 1. Each later digit-selection step can then treat the real and the imaginary residual as two independent real problems.

Each divisor component is rounded to six fractional bits and reduced to its magnitude. The two magnitudes then address a reciprocal table. The address is folded: when the real magnitude has no 1/2 bit, the imaginary magnitude must have it, so the roles of the two components are exchanged. This way one leading bit never has to be stored, and the table needs 11 address bits instead of 12. A rounded component can reach a magnitude of exactly 1. That case has no address in the main table, so a 64-entry side table covers it, and fixed outputs cover the case where both components reach 1. The signs of the divisor components are applied last.

The block holds the divisor in a register when `load` is high. The table path is treated as a three-cycle multicycle path. The result register captures the factor on the third clock edge after the load and then raises `k_rdy`.

Top module: `cdiv_prescale`

## Requirements
- R1: Each divisor component (DW=10 bits, 9 fractional bits) is rounded to 6 fractional bits by adding half of the new LSB and truncating toward minus infinity, so ties round upward. The rounded value carries two integer bits, so it can equal +1 (code 64 in units of 1/64).
- R2: Let the rounded components be a and b, in units of 1/64, with |a| at least 32. Then the magnitude of k_re is round(4096·|a|/(a²+b²)) and the magnitude of k_im is round(4096·|b|/(a²+b²)), both in units of 1/64, with halves rounded away from zero.
- R3: k_re takes the sign of the rounded real component, and k_im takes the opposite sign of the rounded imaginary component; a zero magnitude gives zero.
- R4: When the rounded real magnitude is below 1/2, the lookup uses the exchanged-operand address, and the results still follow R2 and R3.
- R5: When exactly one rounded component has magnitude 1, the results follow R2 and R3 through the side table, which is addressed by the other component's six magnitude bits.
- R6: When both rounded components have magnitude 1, the output (k_re, k_im) is (+1/2, −1/2) for (+1, +1), (+1/2, +1/2) for (+1, −1), (−1/2, −1/2) for (−1, +1) and (−1/2, +1/2) for (−1, −1). In raw codes, ±1/2 is ±32.
- R7: A load captured at clock edge n updates k_re and k_im at edge n+3. k_rdy is low after edge n and through edge n+2, and high from edge n+3 on.
- R8: With load low and no lookup pending, k_re, k_im and k_rdy hold their values whatever the divisor inputs do.
- R9: While rst_n is low, k_re, k_im and k_rdy are zero.
- R10: For every legal divisor, max(|Re(K·d) − 1|, |Im(K·d)|) < 7/128.
- R11: k_re and k_im are 9-bit two's-complement values with 6 fractional bits, and their magnitude never exceeds 2 (code 128).
- R12: A new load while a lookup is pending cancels the pending lookup. The result then appears three edges after the last load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Capture the divisor and start a lookup |
| d_re | input | 10 | Divisor real part, two's complement, 9 fractional bits |
| d_im | input | 10 | Divisor imaginary part, two's complement, 9 fractional bits |
| k_re | output | 9 | Prescale factor real part, two's complement, 6 fractional bits |
| k_im | output | 9 | Prescale factor imaginary part, two's complement, 6 fractional bits |
| k_rdy | output | 1 | Result register holds the factor for the last load |

## Verification
The bench sweeps every rounded divisor grid point whose larger magnitude is at least 1/2, with random sub-LSB offsets, and compares both outputs against the reciprocal computed in real arithmetic. Errors in the exchanged-address path or the sign correction would show up as swapped or mirrored factors on half of the grid. Corners with a unit magnitude, such as inputs of 511/512 or −1, are aimed at the side table and the four fixed outputs; a design that let +1 wrap to −1 or fell back to the main table would return a factor with the wrong sign or far off in size. Tie inputs at ±half an LSB catch rounding toward zero. Restarted and idle loads expose an update on the wrong edge.

// File: rtl/cdp_pkg.sv
package cdp_pkg;

  // Magnitude of one reciprocal component, scaled by 2^sc and rounded to
  // nearest (halves away from zero): round(2^sc * num / (x^2 + y^2)).
  function automatic int unsigned recip_mag(input int unsigned num,
                                            input int unsigned x,
                                            input int unsigned y,
                                            input int unsigned sc);
    longint unsigned den;
    longint unsigned top;
    den = 64'(x) * 64'(x) + 64'(y) * 64'(y);
    if (den == 64'd0) return 32'd0;
    top = (64'(num) << (sc + 32'd1)) + den;
    return 32'(top / (64'd2 * den));
  endfunction

endpackage

// File: rtl/cdp_round.sv
module cdp_round #(
  parameter int DW = 10,
  parameter int Q  = 6
) (
  input  logic signed [DW-1:0] d,
  output logic signed [Q+1:0]  r
);
  localparam int SH = DW - 1 - Q;
  localparam logic signed [DW:0] HALF = (DW+1)'(1) << (SH - 1);

  logic signed [DW:0] ext;
  logic signed [DW:0] sum;

  assign ext = {d[DW-1], d};
  assign sum = ext + HALF;
  // Dropping SH low bits of a two's-complement value is a floor division.
  assign r   = sum[DW:SH];
endmodule

// File: rtl/cdp_fold.sv
module cdp_fold #(
  parameter int Q = 6
) (
  input  logic signed [Q+1:0] rnd_re,
  input  logic signed [Q+1:0] rnd_im,
  output logic                unit_re,
  output logic                unit_im,
  output logic                both_unit,
  output logic                swap,
  output logic [2*Q-2:0]      addr,
  output logic [Q-1:0]        eaddr
);
  localparam logic [Q:0] UNIT = (Q+1)'(1) << Q;

  logic signed [Q+1:0] neg_r;
  logic signed [Q+1:0] neg_i;
  logic [Q:0]          mag_re;
  logic [Q:0]          mag_im;

  assign neg_r  = -rnd_re;
  assign neg_i  = -rnd_im;
  assign mag_re = rnd_re[Q+1] ? neg_r[Q:0] : rnd_re[Q:0];
  assign mag_im = rnd_im[Q+1] ? neg_i[Q:0] : rnd_im[Q:0];

  assign unit_re   = (mag_re == UNIT);
  assign unit_im   = (mag_im == UNIT);
  assign both_unit = unit_re & unit_im;

  // The 1/2 bit of the leading component is implied and left out of the address.
  assign swap  = ~mag_re[Q-1];
  assign addr  = swap ? {mag_im[Q-2:0], mag_re[Q-1:0]}
                      : {mag_re[Q-2:0], mag_im[Q-1:0]};
  assign eaddr = unit_re ? mag_im[Q-1:0] : mag_re[Q-1:0];
endmodule

// File: rtl/cdp_table.sv
module cdp_table
  import cdp_pkg::*;
#(
  parameter int Q = 6,
  parameter int T = 6
) (
  input  logic [2*Q-2:0] addr,
  input  logic [Q-1:0]   eaddr,
  input  logic           unit_re,
  input  logic           unit_im,
  input  logic           swap,
  output logic [T+1:0]   kmag_re,
  output logic [T+1:0]   kmag_im
);
  localparam int AW  = 2 * Q - 1;
  localparam int KMW = T + 2;
  localparam int unsigned SC   = Q + T;
  localparam int unsigned LEAD = 1 << (Q - 1);
  localparam int unsigned UNIT = 1 << Q;
  localparam logic [KMW-1:0] HALF = KMW'(1) << (T - 1);

  int unsigned mx, my, eo;
  int unsigned f_lead, f_other, e_unit, e_other;

  // Main table: the leading component has its 1/2 bit restored.
  always_comb begin
    mx      = LEAD + 32'(addr[AW-1:Q]);
    my      = 32'(addr[Q-1:0]);
    f_lead  = recip_mag(mx, mx, my, SC);
    f_other = recip_mag(my, mx, my, SC);
  end

  // Side table: one component is exactly one.
  always_comb begin
    eo      = 32'(eaddr);
    e_unit  = recip_mag(UNIT, UNIT, eo, SC);
    e_other = recip_mag(eo, UNIT, eo, SC);
  end

  always_comb begin
    if (unit_re && unit_im) begin
      kmag_re = HALF;
      kmag_im = HALF;
    end else if (unit_re) begin
      kmag_re = KMW'(e_unit);
      kmag_im = KMW'(e_other);
    end else if (unit_im) begin
      kmag_re = KMW'(e_other);
      kmag_im = KMW'(e_unit);
    end else if (swap) begin
      kmag_re = KMW'(f_other);
      kmag_im = KMW'(f_lead);
    end else begin
      kmag_re = KMW'(f_lead);
      kmag_im = KMW'(f_other);
    end
  end
endmodule

// File: rtl/cdiv_prescale.sv
module cdiv_prescale #(
  parameter int DW  = 10,
  parameter int Q   = 6,
  parameter int T   = 6,
  parameter int MCP = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic signed [DW-1:0] d_re,
  input  logic signed [DW-1:0] d_im,
  output logic signed [T+2:0] k_re,
  output logic signed [T+2:0] k_im,
  output logic                k_rdy
);
  localparam int RW  = Q + 2;
  localparam int AW  = 2 * Q - 1;
  localparam int KMW = T + 2;
  localparam int KW  = T + 3;
  localparam int CW  = $clog2(MCP + 1);

  logic signed [DW-1:0] d_q [2];
  logic signed [RW-1:0] rnd [2];
  logic                 unit_re, unit_im, both_unit, swap;
  logic [AW-1:0]        addr;
  logic [Q-1:0]         eaddr;
  logic [KMW-1:0]       kmag_re, kmag_im;
  logic                 neg_re, neg_im, re_nz, im_nz;
  logic signed [KW-1:0] k_re_n, k_im_n;
  logic [CW-1:0]        cnt;
  logic                 lookup_fire;

  for (genvar c = 0; c < 2; c++) begin : g_rnd
    cdp_round #(.DW(DW), .Q(Q)) u_rnd (.d(d_q[c]), .r(rnd[c]));
  end

  cdp_fold #(.Q(Q)) u_fold (
    .rnd_re(rnd[0]), .rnd_im(rnd[1]),
    .unit_re(unit_re), .unit_im(unit_im), .both_unit(both_unit),
    .swap(swap), .addr(addr), .eaddr(eaddr)
  );

  cdp_table #(.Q(Q), .T(T)) u_tab (
    .addr(addr), .eaddr(eaddr), .unit_re(unit_re), .unit_im(unit_im),
    .swap(swap), .kmag_re(kmag_re), .kmag_im(kmag_im)
  );

  // Sign correction: real follows the divisor, imaginary is mirrored.
  assign neg_re = rnd[0][RW-1];
  assign neg_im = ~rnd[1][RW-1];
  assign re_nz  = |kmag_re;
  assign im_nz  = |kmag_im;
  assign k_re_n = neg_re ? -$signed({1'b0, kmag_re}) : $signed({1'b0, kmag_re});
  assign k_im_n = neg_im ? -$signed({1'b0, kmag_im}) : $signed({1'b0, kmag_im});

  assign lookup_fire = (cnt == CW'(1)) && !load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_q[0] <= '0;
      d_q[1] <= '0;
      cnt    <= '0;
      k_re   <= '0;
      k_im   <= '0;
      k_rdy  <= 1'b0;
    end else if (load) begin
      d_q[0] <= d_re;
      d_q[1] <= d_im;
      cnt    <= CW'(MCP);
      k_rdy  <= 1'b0;
    end else if (lookup_fire) begin
      k_re   <= k_re_n;
      k_im   <= k_im_n;
      cnt    <= '0;
      k_rdy  <= 1'b1;
    end else if (cnt != '0) begin
      cnt    <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/cdp_checker.sv
module cdp_checker #(
  parameter int T = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               load,
  input logic               lookup_fire,
  input logic               both_unit,
  input logic               neg_re,
  input logic               neg_im,
  input logic               re_nz,
  input logic               im_nz,
  input logic               k_rdy,
  input logic signed [T+2:0] k_re,
  input logic signed [T+2:0] k_im
);
  localparam logic signed [T+2:0] HALF = (T+3)'(1) << (T - 1);
  localparam logic signed [T+2:0] LIM  = (T+3)'(1) << (T + 1);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_fire |=> $stable(k_re) && $stable(k_im));

  p_rdy_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !k_rdy);

  p_rdy_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_fire |=> k_rdy);

  p_both_unit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_fire && both_unit) |=> ((k_re == HALF) || (k_re == -HALF))
                                 && ((k_im == HALF) || (k_im == -HALF)));

  p_sign_re_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_fire && re_nz) |=> ((k_re < 0) == $past(neg_re)));

  p_sign_im_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_fire && im_nz) |=> ((k_im < 0) == $past(neg_im)));

  p_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    k_rdy |-> (k_re <= LIM) && (k_re >= -LIM) && (k_im <= LIM) && (k_im >= -LIM));
endmodule

bind cdiv_prescale cdp_checker #(.T(T)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .lookup_fire(lookup_fire),
  .both_unit(both_unit), .neg_re(neg_re), .neg_im(neg_im),
  .re_nz(re_nz), .im_nz(im_nz), .k_rdy(k_rdy), .k_re(k_re), .k_im(k_im)
);

// File: tb/sim_cdiv_prescale.sv
module sim_cdiv_prescale;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 10;
  localparam int WD = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic signed [DW-1:0] d_re = '0;
  logic signed [DW-1:0] d_im = '0;
  logic signed [8:0] k_re, k_im;
  logic k_rdy;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  cdiv_prescale u0 (.clk(clk), .rst_n(rst_n), .load(load), .d_re(d_re),
                    .d_im(d_im), .k_re(k_re), .k_im(k_im), .k_rdy(k_rdy));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int rnd6(input int raw);
    return int'($floor(real'(raw) / 8.0 + 0.5));
  endfunction

  // One component of 64/(a+ib) times 64, rounded half away from zero.
  function automatic int kexp(input int num, input int a, input int b);
    real v;
    v = 4096.0 * real'(num) / real'(a * a + b * b);
    if (v < 0.0) return -int'($floor(-v + 0.5));
    return int'($floor(v + 0.5));
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int clamp(input int v);
    return (v > 511) ? 511 : ((v < -512) ? -512 : v);
  endfunction

  // Load at edge n, check R7 timing, return at the negedge after edge n+3.
  task automatic apply(input int rr, input int ri);
    int pr, pi;
    pr = int'(k_re);
    pi = int'(k_im);
    @(negedge clk);
    d_re = DW'(rr); d_im = DW'(ri); load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    chk(k_rdy == 1'b0, "R7 rdy low after load", int'(k_rdy), 0);
    @(negedge clk);
    @(negedge clk);
    chk(k_rdy == 1'b0 && int'(k_re) == pr && int'(k_im) == pi,
        "R7 no early update", int'(k_re), pr);
    @(negedge clk);
    chk(k_rdy == 1'b1, "R7 rdy high at third edge", int'(k_rdy), 1);
  endtask

  task automatic check_k(input int rr, input int ri, input string tag);
    int a, b, er, ei;
    real kr, ki, dr, di, e_re, e_im;
    a = rnd6(rr); b = rnd6(ri);
    er = kexp(a, a, b); ei = kexp(-b, a, b);
    chk(int'(k_re) == er, {tag, " k_re"}, int'(k_re), er);
    chk(int'(k_im) == ei, {tag, " k_im"}, int'(k_im), ei);
    chk((k_re < 0) == (er < 0) && (k_im < 0) == (ei < 0), "R3 signs", int'(k_re), er);
    if (iabs(rr) >= 256 || iabs(ri) >= 256) begin
      kr = real'(k_re) / 64.0; ki = real'(k_im) / 64.0;
      dr = real'(rr) / 512.0;  di = real'(ri) / 512.0;
      e_re = kr * dr - ki * di - 1.0;
      e_im = kr * di + ki * dr;
      if (e_re < 0.0) e_re = -e_re;
      if (e_im < 0.0) e_im = -e_im;
      if (e_im > e_re) e_re = e_im;
      chk(e_re < 7.0 / 128.0, "R10 scaling error x1e5", int'(e_re * 1.0e5),
          int'(7.0e5 / 128.0));
    end
  endtask

  initial begin : watchdog
    repeat (WD) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", WD);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    int hr, hi;
    repeat (3) @(negedge clk);
    chk(k_re == 0 && k_im == 0 && k_rdy == 1'b0, "R9 reset outputs", int'(k_re), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(k_rdy == 1'b0 && k_re == 0, "R9 idle after reset", int'(k_rdy), 0);

    // R1: ties round upward; +4/512 -> 1/64, -4/512 -> 0.
    apply(4, 256);
    chk(int'(k_re) == kexp(1, 1, 32), "R1 tie up to 1", int'(k_re), kexp(1, 1, 32));
    apply(-4, 256);
    chk(int'(k_re) == 0, "R1 negative tie to zero", int'(k_re), 0);
    apply(511, 100);
    check_k(511, 100, "R1 rounds to plus one");

    // R6: both components of unit magnitude.
    apply(511, 511);
    chk(int'(k_re) == 32 && int'(k_im) == -32, "R6 (+1,+1)", int'(k_im), -32);
    apply(511, -512);
    chk(int'(k_re) == 32 && int'(k_im) == 32, "R6 (+1,-1)", int'(k_im), 32);
    apply(-512, 511);
    chk(int'(k_re) == -32 && int'(k_im) == -32, "R6 (-1,+1)", int'(k_re), -32);
    apply(-512, -512);
    chk(int'(k_re) == -32 && int'(k_im) == 32, "R6 (-1,-1)", int'(k_re), -32);

    // R5 one unit component, R4 exchanged address.
    apply(-100, -512);
    check_k(-100, -512, "R5 imag unit");
    apply(40, 300);
    check_k(40, 300, "R4 swapped");

    // R8: inputs move, no load, outputs hold.
    hr = int'(k_re); hi = int'(k_im);
    d_re = DW'(-300); d_im = DW'(17);
    repeat (6) @(negedge clk);
    chk(int'(k_re) == hr && int'(k_im) == hi && k_rdy == 1'b1, "R8 hold", int'(k_re), hr);

    // R12: second load one cycle after the first restarts the count.
    @(negedge clk);
    d_re = DW'(300); d_im = DW'(0); load = 1'b1;
    @(negedge clk);
    d_re = DW'(-400); d_im = DW'(200);
    @(negedge clk);
    load = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(k_rdy == 1'b0, "R12 first lookup dropped", int'(k_rdy), 0);
    @(negedge clk);
    chk(k_rdy == 1'b1, "R12 rdy after last load", int'(k_rdy), 1);
    check_k(-400, 200, "R12 result of last load");

    // Sweep over every legal rounded grid point with random sub-LSB offsets.
    for (int a = -64; a <= 64; a++) begin
      for (int b = -64; b <= 64; b++) begin
        int ra, rb, qa, qb;
        string tag;
        if (iabs(a) < 32 && iabs(b) < 32) continue;
        ra = clamp(8 * a + int'($urandom_range(7)) - 4);
        rb = clamp(8 * b + int'($urandom_range(7)) - 4);
        qa = rnd6(ra); qb = rnd6(rb);
        if (iabs(qa) == 64 && iabs(qb) == 64) tag = "R6 sweep";
        else if (iabs(qa) == 64 || iabs(qb) == 64) tag = "R5 sweep";
        else if (iabs(qa) < 32) tag = "R4 sweep";
        else tag = "R2 sweep";
        apply(ra, rb);
        check_k(ra, rb, tag);
        chk(k_re <= 128 && k_re >= -128 && k_im <= 128 && k_im >= -128,
            "R11 range", int'(k_re), 128);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule